// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command (a read or a write) into the series of column addresses that a synchronous DRAM burst walks through. The command carries a starting column, a burst-length code, an ordering select (sequential or interleaved) and an auto-precharge flag. From the clock edge that accepts the command, the block presents one column address per cycle with a valid flag. A last-beat flag marks the final address of a fixed-length burst.

A full-page burst counts through every column of the row and wraps at the top. It runs until a burst-stop or a precharge input ends it. A new column command may arrive on any cycle and replaces whatever burst is running. When a fixed-length burst with auto-precharge set reaches its final beat, a one-cycle pulse tells the row-control logic to start its self-timed precharge.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, col_valid, col_last and ap_done are 0 and col_addr is 0.
- R2: When cmd_valid is sampled high at a clock edge, then after that edge col_valid is 1 and col_addr equals the sampled cmd_col.
- R3: cmd_len selects the burst length: code 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8, and codes 4 to 7 give full page. A fixed-length burst that nothing interrupts holds col_valid high for exactly that many consecutive cycles.
- R4: With cmd_interleave = 0 and length N, beat k carries the start column with its low log2(N) bits replaced by (start + k) mod N. The upper bits stay unchanged.
- R5: With cmd_interleave = 1 and length N, beat k carries the start column with its low log2(N) bits XORed with k.
- R6: In full page, beat k carries (start + k) mod 2^COL_W, so it wraps from the top column to 0. The burst continues until it is stopped or replaced, and cmd_interleave has no effect on it.
- R7: col_last is 1 exactly on the final beat of a fixed-length burst. For length 1 this is the first beat. col_last is never 1 in full page.
- R8: A cmd_valid on any cycle, including mid-burst, restarts the sequence from its own column and length. It takes priority over stop_burst and precharge sampled in the same cycle.
- R9: stop_burst or precharge sampled high without cmd_valid makes col_valid 0 after that edge. The beat shown during that cycle is the last one.
- R10: ap_done is 1 on the cycle of a final beat whose command had cmd_autopre = 1, and 0 at all other times. This includes bursts that are stopped or replaced before their final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Column command (read or write) this cycle |
| cmd_col | input | COL_W | Starting column of the command |
| cmd_len | input | 3 | Burst-length code (0:1, 1:2, 2:4, 3:8, 4-7: full page) |
| cmd_interleave | input | 1 | 1 selects interleaved ordering |
| cmd_autopre | input | 1 | Command carries auto-precharge |
| stop_burst | input | 1 | Burst-stop command |
| precharge | input | 1 | Precharge command to this row |
| col_addr | output | COL_W | Current column address |
| col_valid | output | 1 | col_addr carries a burst beat |
| col_last | output | 1 | Final beat of a fixed-length burst |
| ap_done | output | 1 | Pulse that starts the auto-precharge |

## Verification
The bench builds the block with its default COL_W of 9, so the column space is the full 512-entry row. A directed full-page run that starts near the top therefore crosses the 511-to-0 wrap in a few cycles. Random start columns put every alignment of the 2-, 4- and 8-beat blocks within reach, so the wrap points of both orderings are covered. Random command, stop and precharge traffic lands restarts and terminations on first, middle and final beats, and directed cases cover a command and a stop in the same cycle.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
    localparam int LEN_W      = 3;
    localparam int LOG_MAX_BL = 3;

    typedef enum logic [LEN_W-1:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd4
    } bl_code_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_W-1:0] code_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o
);
    // Any code past the longest fixed length means a whole row.
    assign full_o = (code_i > LEN_W'(LOG_MAX_BL));

    // Bit i of the wrap mask is set when the burst spans more than 2^i columns.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        if (i < LOG_MAX_BL) begin : g_low
            assign mask_o[i] = full_o | (code_i > LEN_W'(i));
        end else begin : g_high
            assign mask_o[i] = full_o;
        end
    end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] addr_o
);
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;

    assign seq_low = (base_i + beat_i) & mask_i;
    assign ilv_low = (base_i ^ beat_i) & mask_i;
    assign addr_o  = (base_i & ~mask_i) | (ilv_i ? ilv_low : seq_low);
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             cmd_interleave,
    input  logic             cmd_autopre,
    input  logic             stop_burst,
    input  logic             precharge,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic             ap_done
);
    typedef struct packed {
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] beat;
        logic [COL_W-1:0] mask;
        logic             full;
        logic             ilv;
        logic             ap;
        logic [COL_W-1:0] addr;
        logic             valid;
        logic             last;
        logic             ap_pulse;
    } st_t;

    st_t st_d, st_q;

    logic [COL_W-1:0] cmd_mask;
    logic             cmd_full;
    logic [COL_W-1:0] beat_inc;
    logic [COL_W-1:0] step_addr;
    logic             stop_any;

    burst_len_decode #(.COL_W(COL_W)) i_len_dec (
        .code_i (cmd_len),
        .mask_o (cmd_mask),
        .full_o (cmd_full)
    );

    assign beat_inc = st_q.beat + COL_W'(1);

    burst_addr_calc #(.COL_W(COL_W)) i_step_calc (
        .base_i (st_q.base),
        .beat_i (beat_inc),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .addr_o (step_addr)
    );

    assign stop_any = stop_burst | precharge;

    always_comb begin
        st_d          = st_q;
        st_d.ap_pulse = 1'b0;
        if (cmd_valid) begin
            st_d.base     = cmd_col;
            st_d.beat     = '0;
            st_d.mask     = cmd_mask;
            st_d.full     = cmd_full;
            st_d.ilv      = cmd_interleave & ~cmd_full;
            st_d.ap       = cmd_autopre;
            st_d.addr     = cmd_col;
            st_d.valid    = 1'b1;
            st_d.last     = ~cmd_full & (cmd_mask == '0);
            st_d.ap_pulse = cmd_autopre & ~cmd_full & (cmd_mask == '0);
        end else if (stop_any) begin
            st_d.valid = 1'b0;
            st_d.last  = 1'b0;
        end else if (st_q.valid && !st_q.last) begin
            st_d.beat     = beat_inc;
            st_d.addr     = step_addr;
            st_d.last     = ~st_q.full & (beat_inc == st_q.mask);
            st_d.ap_pulse = st_q.ap & ~st_q.full & (beat_inc == st_q.mask);
        end else begin
            st_d.valid = 1'b0;
            st_d.last  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col_addr  = st_q.addr;
    assign col_valid = st_q.valid;
    assign col_last  = st_q.last;
    assign ap_done   = st_q.ap_pulse;

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (col_valid && col_addr == $past(cmd_col)));

    // R9
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_any && !cmd_valid) |=> !col_valid);

    // R7
    last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !cmd_valid) |=> !col_valid);

    // R7
    page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && st_q.full) |-> !col_last);

    // R6
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && st_q.full && !cmd_valid && !stop_any)
        |=> (col_valid && col_addr == $past(col_addr) + COL_W'(1)));

    // R10
    ap_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ap_done |-> (col_last && col_valid));
endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
    localparam int COL_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic [2:0]       cmd_len = '0;
    logic             cmd_interleave = 1'b0;
    logic             cmd_autopre = 1'b0;
    logic             stop_burst = 1'b0;
    logic             precharge = 1'b0;
    logic [COL_W-1:0] col_addr;
    logic             col_valid;
    logic             col_last;
    logic             ap_done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_col        (cmd_col),
        .cmd_len        (cmd_len),
        .cmd_interleave (cmd_interleave),
        .cmd_autopre    (cmd_autopre),
        .stop_burst     (stop_burst),
        .precharge      (precharge),
        .col_addr       (col_addr),
        .col_valid      (col_valid),
        .col_last       (col_last),
        .ap_done        (ap_done)
    );

    // Reference state: what the outputs should show after the next edge.
    logic       m_act = 1'b0;
    int         m_start = 0;
    int         m_code = 0;
    logic       m_ilv = 1'b0;
    logic       m_ap = 1'b0;
    int         m_k = 0;
    string      m_why = "R3";

    function automatic bit is_page(int code);
        return code > 3;
    endfunction

    function automatic int blen(int code);
        return 1 << code;
    endfunction

    function automatic int exp_addr(int s, int code, bit ilv, int k);
        int n;
        int hi;
        if (is_page(code)) return (s + k) % 512;
        n  = blen(code);
        hi = s & ~(n - 1);
        if (ilv) return hi | ((s ^ k) & (n - 1));
        return hi | ((s + k) & (n - 1));
    endfunction

    function automatic bit exp_last();
        return m_act && !is_page(m_code) && (m_k == blen(m_code) - 1);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        string at;
        chk(m_why, "valid", int'(col_valid), int'(m_act));
        chk("R7", "last", int'(col_last), int'(exp_last()));
        chk("R10", "ap_done", int'(ap_done), int'(exp_last() && m_ap));
        if (m_act) begin
            if (m_k == 0) at = "R2";
            else if (is_page(m_code)) at = "R6";
            else if (m_ilv) at = "R5";
            else at = "R4";
            chk(at, "addr", int'(col_addr), exp_addr(m_start, m_code, m_ilv, m_k));
        end
    endtask

    // One cycle: check the current outputs, drive new inputs, advance the reference.
    task automatic cyc(input bit c, input int col, input int code, input bit ilv,
                       input bit ap, input bit sb, input bit pc);
        @(negedge clk);
        compare();
        cmd_valid      = c;
        cmd_col        = COL_W'(col);
        cmd_len        = 3'(code);
        cmd_interleave = ilv;
        cmd_autopre    = ap;
        stop_burst     = sb;
        precharge      = pc;
        if (c) begin
            m_act = 1'b1; m_start = col; m_code = code;
            m_ilv = ilv && !is_page(code); m_ap = ap; m_k = 0; m_why = "R8";
        end else if (sb || pc) begin
            m_act = 1'b0; m_why = "R9";
        end else if (m_act) begin
            if (exp_last()) m_act = 1'b0;
            else m_k++;
            m_why = "R3";
        end else begin
            m_why = "R3";
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd20250117;
        void'($urandom(seed));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "valid", int'(col_valid), 0);
        chk("R1", "last", int'(col_last), 0);
        chk("R1", "ap_done", int'(ap_done), 0);
        chk("R1", "addr", int'(col_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after release", int'(col_valid), 0);

        // R7 and R10: length-1 burst with auto-precharge
        cyc(1, 37, 0, 0, 1, 0, 0);
        idle(3);
        // R4: sequential 8 from a mid-block column
        cyc(1, 13, 3, 0, 1, 0, 0);
        idle(10);
        // R5: interleaved 4 and 8
        cyc(1, 6, 2, 1, 0, 0, 0);
        idle(6);
        cyc(1, 205, 3, 1, 1, 0, 0);
        idle(10);
        // R6: full page across the top column, interleave ignored, then stop
        cyc(1, 508, 4, 1, 1, 0, 0);
        idle(8);
        cyc(0, 0, 0, 0, 0, 1, 0);
        idle(3);
        // R9: precharge inside an 8-beat burst
        cyc(1, 100, 3, 0, 1, 0, 0);
        idle(2);
        cyc(0, 0, 0, 0, 0, 0, 1);
        idle(3);
        // R8: restart mid-burst, and command beating a stop in the same cycle
        cyc(1, 40, 3, 0, 1, 0, 0);
        idle(3);
        cyc(1, 250, 2, 0, 1, 1, 1);
        idle(6);
        // R3: two-beat burst back to back with a new one on its last beat
        cyc(1, 511, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        cyc(1, 3, 1, 1, 1, 0, 0);
        idle(4);

        // Random traffic
        for (int i = 0; i < 6000; i++) begin
            bit c, sb, pc;
            c  = ($urandom % 7) == 0;
            sb = ($urandom % 25) == 0;
            pc = ($urandom % 25) == 0;
            cyc(c, int'($urandom % 512), int'($urandom % 8), 1'($urandom),
                1'($urandom), sb, pc);
        end
        idle(12);
        cyc(0, 0, 0, 0, 0, 1, 0);
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule